// File: doc/BRIEF.md
# UART register and interrupt interface

This block is the software-visible control face of a UART. A 32-bit word-addressed bus reads and writes it. It holds the divisor, line, control, FIFO threshold, interrupt mask, IrDA low-power and DMA configuration words. It reports FIFO status flags and returns eight fixed identification bytes. It also keeps the raw interrupt state and combines it with the mask into a single interrupt line.

A write to the data word hands its low byte to the transmit path through a one-cycle valid strobe and sets the transmit interrupt. A read of the data word pops one byte from an attached first-word-fall-through receive FIFO. The FIFO also reports its fill level, and the block compares that level with a trigger threshold to raise the receive interrupt. The serial engines, DMA and loopback live elsewhere.

Top module: `uart_regif`

## Requirements
- R1: After reset every configuration word, the mask and the raw status read as zero and irq_o is low. The flag word reads 0x90 while the transmit FIFO reports empty and the receive FIFO reports empty.
- R2: The register index is byte offset >> 2. Writable words keep only their low bits on read back: integer divisor (index 9) 16 bits, fractional divisor (10) 6 bits, line control (11) 8 bits, control (12) 16 bits, level select (13) 6 bits, mask (14) 11 bits, IrDA low-power (8) 8 bits, DMA control (18) 3 bits.
- R3: Reads at byte offsets 0xFE0, 0xFE4, ... 0xFFC return, in that order, 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R4: The flag word (index 6) carries transmit empty in bit 7, receive full in bit 6, transmit full in bit 5 and receive empty in bit 4. All other bits are 0.
- R5: A write to index 0 drives tx_valid_o high for exactly the next cycle, with tx_data_o equal to the written low byte. The same write sets raw interrupt bit 5.
- R6: A read of index 0 while the receive FIFO is not empty raises rx_pop_o in that cycle and returns rx_data_i zero-extended. With the FIFO empty there is no pop and the read returns 0.
- R7: irq_o is high exactly when raw status (index 15) AND mask is nonzero. A read of index 16 returns that AND.
- R8: A write to index 17 clears each raw status bit written as 1 and leaves the others unchanged.
- R9: The receive trigger is recomputed only when line control or level select is written. Line control bit 4 = 1 enables the FIFO; the trigger is then 4 x level-select bits [5:3], forced to 1 if zero and limited to the FIFO depth. With the FIFO disabled the trigger is 1. Raw bit 4 is set when the fill level rises to or past the trigger and is cleared when it falls below.
- R10: When a receive trigger crossing and a clear of raw bit 4 fall in the same cycle, bit 4 ends up set.
- R11: An access to an undefined index reads 0, raises err_o in the access cycle and changes no state. Writes to read-only indices are ignored without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, same cycle |
| err_o | output | 1 | Undefined offset accessed |
| tx_valid_o | output | 1 | Transmit byte strobe |
| tx_data_o | output | 8 | Transmit byte |
| rx_pop_o | output | 1 | Pop receive FIFO head |
| rx_data_i | input | 8 | Receive FIFO head byte |
| rx_empty_i | input | 1 | Receive FIFO empty |
| rx_full_i | input | 1 | Receive FIFO full |
| rx_level_i | input | LVL_W | Receive FIFO fill level |
| tx_empty_i | input | 1 | Transmit FIFO empty |
| tx_full_i | input | 1 | Transmit FIFO full |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
Software acknowledging the receive interrupt through the clear register can collide, in a single cycle, with the FIFO level climbing past the trigger. The bench first holds the level below the trigger. On one falling edge it then drives both the level up to the trigger and a clear write of bit 4, and afterwards reads the raw status. A bit 4 that survives shows the new event won over the stale acknowledge. A lost bit would leave the receiver stalled with data waiting.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;
  localparam int IDX_W = 10;

  localparam logic [IDX_W-1:0] IX_DATA = 10'd0;
  localparam logic [IDX_W-1:0] IX_FLAG = 10'd6;
  localparam logic [IDX_W-1:0] IX_ILP  = 10'd8;
  localparam logic [IDX_W-1:0] IX_IDIV = 10'd9;
  localparam logic [IDX_W-1:0] IX_FDIV = 10'd10;
  localparam logic [IDX_W-1:0] IX_LINE = 10'd11;
  localparam logic [IDX_W-1:0] IX_CTRL = 10'd12;
  localparam logic [IDX_W-1:0] IX_LSEL = 10'd13;
  localparam logic [IDX_W-1:0] IX_MASK = 10'd14;
  localparam logic [IDX_W-1:0] IX_RAW  = 10'd15;
  localparam logic [IDX_W-1:0] IX_MSKD = 10'd16;
  localparam logic [IDX_W-1:0] IX_CLR  = 10'd17;
  localparam logic [IDX_W-1:0] IX_DMA  = 10'd18;
  localparam logic [6:0]       IX_ID_HI = 7'h7F; // index[9:3] of 0xFE0..0xFFC

  localparam int ILP_W  = 8;
  localparam int IDIV_W = 16;
  localparam int FDIV_W = 6;
  localparam int LINE_W = 8;
  localparam int CTRL_W = 16;
  localparam int LSEL_W = 6;
  localparam int INT_W  = 11;
  localparam int DMA_W  = 3;

  localparam int INT_TX   = 5;
  localparam int INT_RX   = 4;
  localparam int LINE_FEN = 4;

  function automatic logic [7:0] id_byte(input logic [2:0] k);
    case (k)
      3'd0: id_byte = 8'h11;
      3'd1: id_byte = 8'h10;
      3'd2: id_byte = 8'h14;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/uart_regif_cfg.sv
module uart_regif_cfg
  import uart_regif_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic [31:0]         wdata_i,
  output logic [ILP_W-1:0]    ilp_o,
  output logic [IDIV_W-1:0]   idiv_o,
  output logic [FDIV_W-1:0]   fdiv_o,
  output logic [LINE_W-1:0]   line_o,
  output logic [CTRL_W-1:0]   ctrl_o,
  output logic [LSEL_W-1:0]   lsel_o,
  output logic [INT_W-1:0]    mask_o,
  output logic [DMA_W-1:0]    dma_o,
  output logic [LVL_W-1:0]    trig_o
);
  logic [LINE_W-1:0] line_n;
  logic [LSEL_W-1:0] lsel_n;
  logic [LVL_W-1:0]  trig_n;

  assign line_n = (wr_i && idx_i == IX_LINE) ? wdata_i[LINE_W-1:0] : line_o;
  assign lsel_n = (wr_i && idx_i == IX_LSEL) ? wdata_i[LSEL_W-1:0] : lsel_o;

  // threshold in entries: 4 per select step, never 0, never above depth
  always_comb begin
    int calc;
    calc = 4 * int'(lsel_n[5:3]);
    if (!line_n[LINE_FEN] || calc == 0) calc = 1;
    if (calc > DEPTH) calc = DEPTH;
    trig_n = LVL_W'(calc);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ilp_o  <= '0;
      idiv_o <= '0;
      fdiv_o <= '0;
      line_o <= '0;
      ctrl_o <= '0;
      lsel_o <= '0;
      mask_o <= '0;
      dma_o  <= '0;
      trig_o <= LVL_W'(1);
    end else if (wr_i) begin
      line_o <= line_n;
      lsel_o <= lsel_n;
      if (idx_i == IX_LINE || idx_i == IX_LSEL) trig_o <= trig_n;
      case (idx_i)
        IX_ILP:  ilp_o  <= wdata_i[ILP_W-1:0];
        IX_IDIV: idiv_o <= wdata_i[IDIV_W-1:0];
        IX_FDIV: fdiv_o <= wdata_i[FDIV_W-1:0];
        IX_CTRL: ctrl_o <= wdata_i[CTRL_W-1:0];
        IX_MASK: mask_o <= wdata_i[INT_W-1:0];
        IX_DMA:  dma_o  <= wdata_i[DMA_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/uart_regif_irq.sv
module uart_regif_irq
  import uart_regif_pkg::*;
#(
  parameter int LVL_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_set_i,
  input  logic              clr_wr_i,
  input  logic [INT_W-1:0]  clr_val_i,
  input  logic [INT_W-1:0]  mask_i,
  input  logic [LVL_W-1:0]  trig_i,
  input  logic [LVL_W-1:0]  rx_level_i,
  output logic [INT_W-1:0]  raw_o,
  output logic              irq_o
);
  logic             above, above_q;
  logic [INT_W-1:0] raw_n;

  assign above = rx_level_i >= trig_i;

  always_comb begin
    raw_n = raw_o;
    if (clr_wr_i) raw_n = raw_n & ~clr_val_i;
    if (!above) raw_n[INT_RX] = 1'b0;
    if (tx_set_i) raw_n[INT_TX] = 1'b1;
    // a fresh crossing outranks a clear in the same cycle
    if (above && !above_q) raw_n[INT_RX] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_o   <= '0;
      above_q <= 1'b0;
    end else begin
      raw_o   <= raw_n;
      above_q <= above;
    end
  end

  assign irq_o = |(raw_o & mask_i);
endmodule

// File: rtl/uart_regif_rdmux.sv
module uart_regif_rdmux
  import uart_regif_pkg::*;
(
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [ILP_W-1:0]  ilp_i,
  input  logic [IDIV_W-1:0] idiv_i,
  input  logic [FDIV_W-1:0] fdiv_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [LSEL_W-1:0] lsel_i,
  input  logic [INT_W-1:0]  mask_i,
  input  logic [DMA_W-1:0]  dma_i,
  input  logic [INT_W-1:0]  raw_i,
  input  logic [7:0]        flags_i,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_empty_i,
  output logic              hit_o,
  output logic [31:0]       rdata_o
);
  always_comb begin
    hit_o   = 1'b1;
    rdata_o = '0;
    if (idx_i[IDX_W-1:3] == IX_ID_HI) begin
      rdata_o = {24'd0, id_byte(idx_i[2:0])};
    end else begin
      case (idx_i)
        IX_DATA: rdata_o = rx_empty_i ? 32'd0 : {24'd0, rx_data_i};
        IX_FLAG: rdata_o = {24'd0, flags_i};
        IX_ILP:  rdata_o = 32'(ilp_i);
        IX_IDIV: rdata_o = 32'(idiv_i);
        IX_FDIV: rdata_o = 32'(fdiv_i);
        IX_LINE: rdata_o = 32'(line_i);
        IX_CTRL: rdata_o = 32'(ctrl_i);
        IX_LSEL: rdata_o = 32'(lsel_i);
        IX_MASK: rdata_o = 32'(mask_i);
        IX_RAW:  rdata_o = 32'(raw_i);
        IX_MSKD: rdata_o = 32'(raw_i & mask_i);
        IX_CLR:  rdata_o = '0;
        IX_DMA:  rdata_o = 32'(dma_i);
        default: hit_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/uart_regif.sv
module uart_regif
  import uart_regif_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DEPTH  = 16,
  parameter int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              err_o,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  output logic              rx_pop_o,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_empty_i,
  input  logic              rx_full_i,
  input  logic [LVL_W-1:0]  rx_level_i,
  input  logic              tx_empty_i,
  input  logic              tx_full_i,
  output logic              irq_o
);
  logic [IDX_W-1:0]  idx;
  logic              hit, wr, rd;
  logic [31:0]       mux_data;
  logic [ILP_W-1:0]  ilp_q;
  logic [IDIV_W-1:0] idiv_q;
  logic [FDIV_W-1:0] fdiv_q;
  logic [LINE_W-1:0] line_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [LSEL_W-1:0] lsel_q;
  logic [INT_W-1:0]  imsc_q;
  logic [DMA_W-1:0]  dma_q;
  logic [LVL_W-1:0]  trig_q;
  logic [INT_W-1:0]  raw_q;
  logic [7:0]        flags;

  assign idx   = IDX_W'(addr_i[ADDR_W-1:2]);
  assign wr    = req_i && we_i && hit;
  assign rd    = req_i && !we_i && hit;
  assign flags = {tx_empty_i, rx_full_i, tx_full_i, rx_empty_i, 4'd0};

  uart_regif_cfg #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_cfg (
    .clk_i, .rst_ni, .wr_i(wr), .idx_i(idx), .wdata_i,
    .ilp_o(ilp_q), .idiv_o(idiv_q), .fdiv_o(fdiv_q), .line_o(line_q),
    .ctrl_o(ctrl_q), .lsel_o(lsel_q), .mask_o(imsc_q), .dma_o(dma_q),
    .trig_o(trig_q)
  );

  uart_regif_irq #(.LVL_W(LVL_W)) u_irq (
    .clk_i, .rst_ni,
    .tx_set_i(wr && idx == IX_DATA),
    .clr_wr_i(wr && idx == IX_CLR),
    .clr_val_i(wdata_i[INT_W-1:0]),
    .mask_i(imsc_q), .trig_i(trig_q), .rx_level_i,
    .raw_o(raw_q), .irq_o
  );

  uart_regif_rdmux u_rdmux (
    .idx_i(idx), .ilp_i(ilp_q), .idiv_i(idiv_q), .fdiv_i(fdiv_q),
    .line_i(line_q), .ctrl_i(ctrl_q), .lsel_i(lsel_q), .mask_i(imsc_q),
    .dma_i(dma_q), .raw_i(raw_q), .flags_i(flags), .rx_data_i,
    .rx_empty_i, .hit_o(hit), .rdata_o(mux_data)
  );

  assign rdata_o  = rd ? mux_data : 32'd0;
  assign err_o    = req_i && !hit;
  assign rx_pop_o = rd && idx == IX_DATA && !rx_empty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_valid_o <= 1'b0;
      tx_data_o  <= '0;
    end else begin
      tx_valid_o <= wr && idx == IX_DATA;
      if (wr && idx == IX_DATA) tx_data_o <= wdata_i[7:0];
    end
  end
endmodule

// File: rtl/uart_regif_sva.sv
module uart_regif_sva
  import uart_regif_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_o,
  input logic              err_o,
  input logic              tx_valid_o,
  input logic [7:0]        tx_data_o,
  input logic              rx_pop_o,
  input logic              rx_empty_i,
  input logic              irq_o,
  input logic [INT_W-1:0]  raw_q,
  input logic [INT_W-1:0]  imsc_q
);
  logic [IDX_W-1:0] idx;
  logic             dwr, cwr;
  assign idx = IDX_W'(addr_i[ADDR_W-1:2]);
  assign dwr = req_i && we_i && idx == IX_DATA;
  assign cwr = req_i && we_i && idx == IX_CLR;

  p_tx_strobe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dwr |=> tx_valid_o && tx_data_o == $past(wdata_i[7:0]));
  p_tx_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> $past(dwr));
  p_tx_raw_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dwr |=> raw_q[INT_TX]);
  p_pop_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pop_o |-> req_i && !we_i && !rx_empty_i);
  p_quiet_mask_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (imsc_q == '0) |-> !irq_o);
  p_clear_tx_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cwr && wdata_i[INT_TX]) |=> !raw_q[INT_TX]);
  p_err_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !we_i) |-> rdata_o == 32'd0);
  p_err_req_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> req_i);
endmodule

bind uart_regif uart_regif_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .err_o(err_o),
  .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o), .rx_pop_o(rx_pop_o),
  .rx_empty_i(rx_empty_i), .irq_o(irq_o), .raw_q(raw_q), .imsc_q(imsc_q)
);

// File: tb/uart_regif_tb.sv
module uart_regif_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam int LVL_W  = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req = 1'b0, we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic              err, tx_valid, rx_pop, irq;
  logic [7:0]        tx_data;
  logic [7:0]        rx_data = 8'h00;
  logic              rx_empty = 1'b1, rx_full = 1'b0;
  logic              tx_empty = 1'b1, tx_full = 1'b0;
  logic [LVL_W-1:0]  rx_level = '0;
  int total = 0, bad = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_regif #(.ADDR_W(ADDR_W), .DEPTH(16), .LVL_W(LVL_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .err_o(err), .tx_valid_o(tx_valid),
    .tx_data_o(tx_data), .rx_pop_o(rx_pop), .rx_data_i(rx_data),
    .rx_empty_i(rx_empty), .rx_full_i(rx_full), .rx_level_i(rx_level),
    .tx_empty_i(tx_empty), .tx_full_i(tx_full), .irq_o(irq)
  );

  task automatic chk(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req_tag, act, exp);
    end
  endtask

  logic s_err, s_pop;

  task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    #1 s_err = err;
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata; s_err = err; s_pop = rx_pop;
    @(posedge clk); #1;
    req = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 irq", 32'(irq), 0);
    bus_rd(12'h018, d); chk("R1 flags", d, 32'h90);
    bus_rd(12'h024, d); chk("R1 idiv", d, 0);
    bus_rd(12'h038, d); chk("R1 mask", d, 0);
    bus_rd(12'h03C, d); chk("R1 raw", d, 0);
  endtask

  task automatic t_cfg;
    logic [31:0] d;
    logic [ADDR_W-1:0] a [8] = '{12'h020, 12'h024, 12'h028, 12'h02C,
                                 12'h030, 12'h034, 12'h038, 12'h048};
    logic [31:0] m [8] = '{32'hFF, 32'hFFFF, 32'h3F, 32'hFF,
                           32'hFFFF, 32'h3F, 32'h7FF, 32'h7};
    for (int i = 0; i < 8; i++) begin
      bus_wr(a[i], 32'hFFFF_FFFF);
      bus_rd(a[i], d); chk("R2 width", d, m[i]);
    end
    for (int i = 0; i < 8; i++) bus_wr(a[i], 32'h0);
  endtask

  task automatic t_id;
    logic [31:0] d;
    logic [7:0] ids [8] = '{8'h11, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    for (int i = 0; i < 8; i++) begin
      bus_rd(ADDR_W'(12'hFE0 + 4*i), d); chk("R3 id", d, 32'(ids[i]));
    end
  endtask

  task automatic t_flags;
    logic [31:0] d;
    tx_empty = 1'b0; rx_full = 1'b1; tx_full = 1'b1; rx_empty = 1'b0;
    bus_rd(12'h018, d); chk("R4 flags", d, 32'h60);
    tx_empty = 1'b1; rx_full = 1'b0; tx_full = 1'b0; rx_empty = 1'b1;
    bus_wr(12'h018, 32'hFFFF_FFFF);
    chk("R11 ro write no err", 32'(s_err), 0);
    bus_rd(12'h018, d); chk("R4 flags idle", d, 32'h90);
  endtask

  task automatic t_tx;
    logic [31:0] d;
    bus_wr(12'h000, 32'h1234_56C3);
    chk("R5 valid", 32'(tx_valid), 1);
    chk("R5 data", 32'(tx_data), 32'hC3);
    @(posedge clk); #1;
    chk("R5 one cycle", 32'(tx_valid), 0);
    bus_rd(12'h03C, d); chk("R5 raw tx", d, 32'h20);
  endtask

  task automatic t_rx;
    logic [31:0] d;
    rx_empty = 1'b0; rx_data = 8'hA5;
    bus_rd(12'h000, d);
    chk("R6 data", d, 32'hA5); chk("R6 pop", 32'(s_pop), 1);
    rx_empty = 1'b1;
    bus_rd(12'h000, d);
    chk("R6 empty data", d, 0); chk("R6 empty pop", 32'(s_pop), 0);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    chk("R7 unmasked irq low", 32'(irq), 0);
    bus_wr(12'h038, 32'h30);
    chk("R7 irq high", 32'(irq), 1);
    bus_rd(12'h040, d); chk("R7 masked read", d, 32'h20);
    bus_wr(12'h038, 32'h10);
    chk("R7 irq off", 32'(irq), 0);
    bus_rd(12'h040, d); chk("R7 masked zero", d, 0);
  endtask

  task automatic t_clear;
    logic [31:0] d;
    bus_wr(12'h044, 32'h10);
    bus_rd(12'h03C, d); chk("R8 other bit kept", d, 32'h20);
    bus_wr(12'h044, 32'h20);
    bus_rd(12'h03C, d); chk("R8 cleared", d, 0);
  endtask

  task automatic t_trigger;
    logic [31:0] d;
    @(negedge clk); rx_level = 5'd1;
    bus_rd(12'h03C, d); chk("R9 trig1 set", d, 32'h10);
    chk("R9 irq via mask", 32'(irq), 1);
    @(negedge clk); rx_level = 5'd0;
    bus_rd(12'h03C, d); chk("R9 trig1 drop", d, 0);
    bus_wr(12'h02C, 32'h10);
    bus_wr(12'h034, 32'h10);
    @(negedge clk); rx_level = 5'd7;
    bus_rd(12'h03C, d); chk("R9 below 8", d, 0);
    @(negedge clk); rx_level = 5'd8;
    bus_rd(12'h03C, d); chk("R9 at 8", d, 32'h10);
    @(negedge clk); rx_level = 5'd4;
    bus_rd(12'h03C, d); chk("R9 fall", d, 0);
    bus_wr(12'h034, 32'h38);
    @(negedge clk); rx_level = 5'd16;
    bus_rd(12'h03C, d); chk("R9 clamp depth", d, 32'h10);
    @(negedge clk); rx_level = 5'd0;
    bus_wr(12'h034, 32'h10);
  endtask

  task automatic t_collide;
    logic [31:0] d;
    rx_level = 5'd7;
    @(posedge clk); #1;
    @(negedge clk);
    rx_level = 5'd8; req = 1'b1; we = 1'b1; addr = 12'h044; wdata = 32'h10;
    @(posedge clk); #1; req = 1'b0; we = 1'b0;
    bus_rd(12'h03C, d); chk("R10 set wins", d, 32'h10);
    rx_level = 5'd0;
  endtask

  task automatic t_undef;
    logic [31:0] d;
    bus_wr(12'h024, 32'h55);
    bus_wr(12'h00C, 32'hFFFF);
    chk("R11 write err", 32'(s_err), 1);
    bus_rd(12'h00C, d);
    chk("R11 rdata", d, 0); chk("R11 read err", 32'(s_err), 1);
    bus_wr(12'h800, 32'hFFFF);
    chk("R11 far err", 32'(s_err), 1);
    bus_rd(12'h024, d); chk("R11 no side effect", d, 32'h55);
    bus_rd(12'h024, d); chk("R11 err cleared", 32'(s_err), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_cfg();
    t_id();
    t_flags();
    t_tx();
    t_rx();
    t_mask();
    t_clear();
    t_trigger();
    t_collide();
    t_undef();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=hung exp=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule